// File: doc/BRIEF.md
# Burst Column Sequencer with Read and Mask Latency

This block sits behind the command decoder of one memory bank and turns a single read or write start into a per-cycle stream of column addresses. It takes the start column, the programmed burst length and ordering, the CAS latency and the mask-latency option. It then produces the column address for each beat, a read-data-valid flag with byte-lane enables delayed to match the CAS latency, and byte-lane write strobes for write beats.

Beats begin in the cycle after the start is sampled and advance one per clock while the clock enable is high. A low clock enable freezes every counter and delay stage for that cycle. A stop request (burst terminate or precharge) ends a write burst at once. For a read it ends the burst at the column generator, so words already in the latency pipe still drain.

Top module: `burst_col_pipe`

## Requirements
- R1: After reset, colValid, rdValid, rdByteEn and wrStrobe are all zero until a start is sampled.
- R2: lenCode selects the beat count: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 with interleave low gives 256. Codes 4, 5 and 6, and code 7 with interleave high, give 1. Beat 0 is presented in the cycle after the start is sampled, with one beat per enabled cycle after that. A start with both rdStart and wrStart high is a read.
- R3: With interleave low (sequential), beat n has address (startCol + n) taken modulo the burst length, kept inside the burst-length-aligned block that holds startCol.
- R4: With interleave high, beat n has address startCol XOR n.
- R5: casLat values 1, 2 and 3 give that latency, and value 0 is treated as 1. The first rdValid is in the cycle casLat cycles after the read start cycle, with one rdValid per read beat.
- R6: For reads, a dqm bit set in cycle c clears that lane of rdByteEn in cycle c+2, and rdByteEn is zero whenever rdValid is low.
- R7: When dqmShort is high and the effective CAS latency is 1, the read mask latency is 1 cycle. In every other case it is 2.
- R8: In a write beat cycle, wrStrobe equals the inverse of dqm in that same cycle (bit i is byte lane i). wrStrobe is zero outside write beats.
- R9: A stopReq in cycle c during a read suppresses all read data from cycle c+casLat onward. Data due before that is still delivered.
- R10: A stopReq in a write beat cycle forces wrStrobe to zero in that cycle, and no further beats follow. A start in the same cycle takes precedence over the stop.
- R11: While cke is low, the beat counter, the address and every latency stage hold their state, and wrStrobe is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable; low freezes the pipeline |
| rdStart | input | 1 | Start a read burst |
| wrStart | input | 1 | Start a write burst |
| stopReq | input | 1 | Burst terminate or precharge request |
| startCol | input | 8 | Start column of the burst |
| lenCode | input | 3 | Burst length code |
| interleave | input | 1 | 1 = interleaved ordering, 0 = sequential |
| casLat | input | 2 | CAS latency in cycles |
| dqmShort | input | 1 | Select 1-cycle read mask latency (valid with latency 1 only) |
| dqm | input | 4 | Byte-lane mask, one bit per byte |
| colAddr | output | 8 | Column address of the current beat |
| colValid | output | 1 | A beat is presented this cycle |
| rdValid | output | 1 | Read data word due this cycle |
| rdByteEn | output | 4 | Read byte-lane output enables |
| wrStrobe | output | 4 | Write byte-lane strobes |

## Verification
Column addresses appear one cycle after the start and then one per enabled cycle, so every beat is compared in the cycle its index predicts. rdValid is due casLat cycles after the read start. A read mask takes effect one or two cycles after dqm is driven, and write strobes respond in the same cycle. Inputs change just after a rising edge and outputs are sampled a nanosecond later. Each check is tied to a cycle count from the start cycle, and stop and freeze tests mark the exact cycle where the stream must break or repeat.

// File: rtl/burst_pipe_pkg.sv
package burst_pipe_pkg;
  localparam int COL_W = 8;
  localparam int LANES = 4;
  localparam int MAX_CL = 3;

  typedef struct packed {
    logic             load;
    logic             beat;
    logic             isWrite;
    logic             interleave;
    logic [COL_W-1:0] beatIdx;
    logic [COL_W-1:0] mask;
  } ctrlStrobe_t;

  function automatic logic [COL_W-1:0] lenMask(input logic [2:0] code, input logic ilv);
    case (code)
      3'd1:    lenMask = COL_W'(1);
      3'd2:    lenMask = COL_W'(3);
      3'd3:    lenMask = COL_W'(7);
      3'd7:    lenMask = ilv ? '0 : {COL_W{1'b1}};
      default: lenMask = '0;
    endcase
  endfunction
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_pipe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cke,
  input  logic        rdStart,
  input  logic        wrStart,
  input  logic        stopReq,
  input  logic [2:0]  lenCode,
  input  logic        interleave,
  output ctrlStrobe_t strobe
);
  logic             active;
  logic             isWrite;
  logic             ilvQ;
  logic [COL_W-1:0] cnt;
  logic [COL_W-1:0] lastIdx;
  logic             load;

  assign load = cke && (rdStart || wrStart);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      isWrite <= 1'b0;
      ilvQ    <= 1'b0;
      cnt     <= '0;
      lastIdx <= '0;
    end else if (cke) begin
      if (load) begin
        active  <= 1'b1;
        isWrite <= !rdStart;
        ilvQ    <= interleave;
        cnt     <= '0;
        lastIdx <= lenMask(lenCode, interleave);
      end else if (stopReq) begin
        active <= 1'b0;
      end else if (active) begin
        if (cnt == lastIdx) active <= 1'b0;
        else                cnt    <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load       = load;
    strobe.beat       = active;
    strobe.isWrite    = isWrite;
    strobe.interleave = ilvQ;
    strobe.beatIdx    = cnt;
    strobe.mask       = lastIdx;
  end

  // R10: a stop without a start ends the burst
  assert_stop_ends_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cke && stopReq && !rdStart && !wrStart) |=> !active);

  // R11: suspended cycle holds counter and activity
  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> ($stable(cnt) && $stable(active)));

  // R2: one beat per enabled cycle until the last index
  assert_beat_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cke && active && !load && !stopReq && cnt != lastIdx) |=> (active && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/burst_data_path.sv
module burst_data_path
  import burst_pipe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  ctrlStrobe_t      strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       casLat,
  input  logic             dqmShort,
  input  logic             stopReq,
  input  logic [LANES-1:0] dqm,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             rdValid,
  output logic [LANES-1:0] rdByteEn,
  output logic [LANES-1:0] wrStrobe
);
  localparam int STAGES = MAX_CL - 1;

  logic [COL_W-1:0]  startQ;
  logic [COL_W-1:0]  seqAddr;
  logic [STAGES-1:0] rdStage;
  logic [MAX_CL-1:0] rdTap;
  logic [1:0]        clIdx;
  logic              readBeat;
  logic [LANES-1:0]  dqmDly [1:2];
  logic [LANES-1:0]  dqmSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            startQ <= '0;
    else if (strobe.load) startQ <= startCol;
  end

  assign seqAddr  = startQ + strobe.beatIdx;
  assign colAddr  = strobe.interleave ? (startQ ^ strobe.beatIdx)
                                      : ((startQ & ~strobe.mask) | (seqAddr & strobe.mask));
  assign colValid = strobe.beat;

  assign readBeat = strobe.beat && !strobe.isWrite;
  assign clIdx    = (casLat == 2'd0) ? 2'd0 : casLat - 2'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    rdStage <= '0;
    else if (cke) rdStage <= {rdStage[STAGES-2:0], readBeat};
  end

  assign rdTap   = {rdStage, readBeat};
  assign rdValid = rdTap[clIdx];

  generate
    for (genvar d = 1; d <= 2; d++) begin : g_dqmDelay
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    dqmDly[d] <= '0;
        else if (cke) dqmDly[d] <= (d == 1) ? dqm : dqmDly[1];
      end
    end
  endgenerate

  assign dqmSel   = (dqmShort && clIdx == 2'd0) ? dqmDly[1] : dqmDly[2];
  assign rdByteEn = rdValid ? ~dqmSel : '0;
  assign wrStrobe = (strobe.beat && strobe.isWrite && cke && !stopReq) ? ~dqm : '0;

  // R5: with latency 2 a read beat yields data in the next cycle
  assert_cl2_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cke && clIdx == 2'd1 && readBeat) |=> (rdValid || clIdx != 2'd1));

  // R3: every address stays in the aligned block of the start column
  assert_block_R3: assert property (@(posedge clk) disable iff (!rstN)
    colValid |-> ((colAddr & ~strobe.mask) == (startQ & ~strobe.mask)));

  // R6: no enables without read data
  assert_en_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdByteEn == '0));
endmodule

// File: rtl/burst_col_pipe.sv
module burst_col_pipe
  import burst_pipe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cke,
  input  logic             rdStart,
  input  logic             wrStart,
  input  logic             stopReq,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             interleave,
  input  logic [1:0]       casLat,
  input  logic             dqmShort,
  input  logic [LANES-1:0] dqm,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             rdValid,
  output logic [LANES-1:0] rdByteEn,
  output logic [LANES-1:0] wrStrobe
);
  ctrlStrobe_t strobe;

  burst_seq_ctrl u_ctrl (
    .clk, .rstN, .cke, .rdStart, .wrStart, .stopReq, .lenCode, .interleave,
    .strobe
  );

  burst_data_path u_data (
    .clk, .rstN, .cke, .strobe, .startCol, .casLat, .dqmShort, .stopReq, .dqm,
    .colAddr, .colValid, .rdValid, .rdByteEn, .wrStrobe
  );

  // R8: write strobes only appear during an enabled beat
  assert_wr_only_beat_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe != '0) |-> (colValid && cke));
endmodule

// File: tb/burst_col_pipe_bench.sv
module burst_col_pipe_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, rdStart = 1'b0, wrStart = 1'b0, stopReq = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic interleave = 1'b0, dqmShort = 1'b0;
  logic [1:0] casLat = 2'd1;
  logic [3:0] dqm = '0;
  logic [7:0] colAddr;
  logic colValid, rdValid;
  logic [3:0] rdByteEn, wrStrobe;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  burst_col_pipe u_burst_col_pipe (.*);

  // fields: start, lenCode, interleave, beats, addr0..addr3
  localparam logic [52:0] VECS [0:8] = '{
    {8'h05, 3'd2, 1'b0, 9'd4,   8'h05, 8'h06, 8'h07, 8'h04},
    {8'h05, 3'd2, 1'b1, 9'd4,   8'h05, 8'h04, 8'h07, 8'h06},
    {8'h0E, 3'd3, 1'b0, 9'd8,   8'h0E, 8'h0F, 8'h08, 8'h09},
    {8'h0E, 3'd3, 1'b1, 9'd8,   8'h0E, 8'h0F, 8'h0C, 8'h0D},
    {8'h13, 3'd1, 1'b0, 9'd2,   8'h13, 8'h12, 8'h00, 8'h00},
    {8'hFE, 3'd7, 1'b0, 9'd256, 8'hFE, 8'hFF, 8'h00, 8'h01},
    {8'hFE, 3'd7, 1'b1, 9'd1,   8'hFE, 8'h00, 8'h00, 8'h00},
    {8'h40, 3'd4, 1'b0, 9'd1,   8'h40, 8'h00, 8'h00, 8'h00},
    {8'h21, 3'd0, 1'b0, 9'd1,   8'h21, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // drives a start, then returns in cycle k=1 (first beat cycle)
  task automatic launch(input logic rd, input logic [7:0] sc, input logic [2:0] lc, input logic ilv);
    startCol = sc; lenCode = lc; interleave = ilv;
    rdStart = rd; wrStart = !rd;
    tick();
    rdStart = 1'b0; wrStart = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int first, cnt;
    logic [7:0] a;
    repeat (3) tick();
    chk("R1 colValid at reset", colValid, 0);
    chk("R1 rdValid at reset", rdValid, 0);
    chk("R1 wrStrobe at reset", wrStrobe, 0);
    rstN = 1'b1;
    tick();
    chk("R1 idle after reset", {colValid, rdValid, rdByteEn, wrStrobe}, 0);

    // R2 R3 R4: table walk of address sequences and beat counts
    for (int v = 0; v < 9; v++) begin
      launch(1'b0, VECS[v][52:45], VECS[v][44:42], VECS[v][41]);
      cnt = 0;
      for (int k = 0; k < 300 && colValid; k++) begin
        if (k < 4 && k < int'(VECS[v][40:32])) begin
          a = VECS[v][31 - 8*k -: 8];
          chk(VECS[v][41] ? "R4 interleaved address" : "R3 sequential address", colAddr, a);
        end
        cnt++;
        tick();
      end
      chk("R2 beat count", cnt, int'(VECS[v][40:32]));
    end

    // R2: both starts high is a read
    casLat = 2'd1;
    startCol = 8'h00; lenCode = 3'd0; rdStart = 1'b1; wrStart = 1'b1; tick();
    rdStart = 1'b0; wrStart = 1'b0;
    chk("R2 dual start is read", {rdValid, wrStrobe}, 5'b10000);
    tick();

    // R5: CAS latency 0..3
    for (int cl = 0; cl < 4; cl++) begin
      casLat = 2'(cl);
      launch(1'b1, 8'h00, 3'd2, 1'b0);
      first = 0; cnt = 0;
      for (int k = 1; k <= 8; k++) begin
        if (rdValid) begin cnt++; if (first == 0) first = k; end
        tick();
      end
      chk("R5 first data cycle", first, (cl == 0) ? 1 : cl);
      chk("R5 data count", cnt, 4);
    end

    // R6 R7: read mask latency; dqm set in cycle 2
    for (int t = 0; t < 3; t++) begin
      int expK;
      casLat   = (t == 1) ? 2'd1 : 2'd2;
      dqmShort = (t != 0);
      expK     = (t == 1) ? 3 : 4;
      launch(1'b1, 8'h00, 3'd2, 1'b0);
      for (int k = 1; k <= 6; k++) begin
        dqm = (k == 2) ? 4'b0011 : 4'b0000;
        #1;
        if (rdValid)
          chk((t == 1) ? "R7 short mask latency" : "R6 mask latency two",
              rdByteEn, (k == expK) ? 4'b1100 : 4'b1111);
        else
          chk("R6 enables off without data", rdByteEn, 0);
        tick();
      end
      dqm = '0;
    end
    dqmShort = 1'b0;

    // R8: write mask zero latency
    launch(1'b0, 8'h00, 3'd2, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      dqm = (k == 2) ? 4'b1010 : 4'b0000;
      #1;
      chk("R8 write strobe", wrStrobe, (k == 5) ? 4'b0000 : ((k == 2) ? 4'b0101 : 4'b1111));
      tick();
    end
    dqm = '0;

    // R9: read stop with latency 3, stop in cycle 2
    casLat = 2'd3;
    launch(1'b1, 8'h00, 3'd3, 1'b0);
    cnt = 0;
    for (int k = 1; k <= 10; k++) begin
      stopReq = (k == 2);
      #1;
      if (k == 4) chk("R9 data before stop delivered", rdValid, 1);
      if (k == 5) chk("R9 data after stop latency suppressed", rdValid, 0);
      if (rdValid) cnt++;
      tick();
    end
    stopReq = 1'b0;
    chk("R9 words delivered", cnt, 2);

    // R10: write stop in cycle 2
    launch(1'b0, 8'h00, 3'd3, 1'b0);
    chk("R10 beat before stop", wrStrobe, 4'b1111);
    tick();
    stopReq = 1'b1; #1;
    chk("R10 stop masks write", wrStrobe, 0);
    tick();
    stopReq = 1'b0;
    chk("R10 no beat after stop", colValid, 0);

    // R10: start beats a same-cycle stop
    startCol = 8'h30; lenCode = 3'd1; wrStart = 1'b1; stopReq = 1'b1; tick();
    wrStart = 1'b0; stopReq = 1'b0;
    chk("R10 start wins over stop", {colValid, colAddr}, {1'b1, 8'h30});
    tick(); tick();

    // R11: clock enable low in cycle 2 of a write
    launch(1'b0, 8'h10, 3'd2, 1'b0);
    chk("R11 beat0 address", colAddr, 8'h10);
    tick();
    cke = 1'b0; #1;
    chk("R11 address held", colAddr, 8'h11);
    chk("R11 no write while suspended", wrStrobe, 0);
    tick();
    cke = 1'b1; #1;
    chk("R11 address repeats after resume", colAddr, 8'h11);
    chk("R11 write resumes", wrStrobe, 4'b1111);
    tick();
    chk("R11 next address", colAddr, 8'h12);
    tick(); tick();
    chk("R11 burst ends after four beats", colValid, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule